// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the architectural register state of a small 32-bit RISC core. It has sixteen general registers, numbered 0 to 15. Registers 0 to 7 exist twice, as bank 0 and bank 1. Registers 8 to 15 exist once and are common to both banks. A set of system registers sits beside them: the multiply-accumulate high and low words, the global base, the procedure return address, the status word and the program counter. Three control registers are reserved for privileged code: the saved status, the vector base and the saved program counter.

The status word inside the block holds a privilege bit and a bank-select bit. Together they decide which copy of registers 0 to 7 the two read ports and the write port see. User mode always works on bank 0. Privileged mode works on the bank named by the bank-select bit. A separate alternate port reaches the copy that is not active, which is the path control-register move instructions use.

Any access that user mode is not allowed to make is refused in the same cycle. This covers the alternate port and the three privileged control registers. A refused access raises an illegal-access flag, reads as zero and changes no state. Register 0 of the active bank is always driven on a separate output, for use as the index operand in indexed addressing.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset sets the status word to 32'h6000_0000 (privileged, bank 1 active) and clears the program counter, every general register in both banks and every other system register to zero.
- R2: While status bit 30 (privilege) is 0, general registers 0 to 7 on the read and write ports map to bank 0, whatever the value of status bit 29.
- R3: While status bit 30 is 1, registers 0 to 7 on the read and write ports map to bank 1 when status bit 29 is 1, and to bank 0 when it is 0.
- R4: General registers 8 to 15 are one physical set: a value written under any mode and bank setting reads back unchanged under every other setting.
- R5: In privileged mode the alternate port (3-bit register number) reads and writes the bank that is not active.
- R6: In user mode, the following are refused: any use of the alternate port, and any read or write of system code 6 (saved status), 7 (vector base) or 8 (saved program counter). A refused access drives illegal high in that cycle, returns zero on the affected read data, and leaves all register state unchanged.
- R7: All writes commit on the rising clock edge. A read of a register in the cycle it is being written returns the old value, and the new value appears from the next cycle.
- R8: idx_data always equals register 0 of the currently active bank.
- R9: The system codes 0 (MAC high), 1 (MAC low), 2 (global base), 3 (return address), 4 (status) and 5 (program counter) can be read and written in both modes. A status write changes the bank mapping from the next cycle on.
- R10: System codes 9 to 15 read as zero, ignore writes, and do not raise illegal. A system read with sys_rd_en low returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_addr | input | 4 | General register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 4 | General register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable for the general write port |
| wr_addr | input | 4 | General register number to write |
| wr_data | input | 32 | General write data |
| alt_rd_en | input | 1 | Read request on the alternate (inactive bank) port |
| alt_wr_en | input | 1 | Write request on the alternate port |
| alt_addr | input | 3 | Register number 0 to 7 within the inactive bank |
| alt_wdata | input | 32 | Alternate port write data |
| alt_rdata | output | 32 | Alternate port read data, zero when not enabled or refused |
| sys_rd_en | input | 1 | System register read request |
| sys_wr_en | input | 1 | System register write request |
| sys_sel | input | 4 | System register code, 0 to 8 mapped |
| sys_wdata | input | 32 | System register write data |
| sys_rdata | output | 32 | System register read data |
| idx_data | output | 32 | Register 0 of the active bank |
| illegal | output | 1 | User-mode access to a privileged resource this cycle |

## Verification
Some properties are checked on every cycle. User mode always selects bank 0. In privileged mode the active bank follows the bank bit, and the alternate port always faces the other bank. A refused access happens only in user mode and reads as zero. Register state holds still whenever no write is let through, and reset clears the state.

Other behaviour only the bench scenarios can show. Each bank really keeps its own contents across every combination of mode and bank bit. A refused write leaves no trace once privilege returns. The old value is seen in the cycle of a write, including a status write that flips the bank.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

    localparam int SR_PRIV_BIT = 30;
    localparam int SR_BANK_BIT = 29;

    typedef enum logic [3:0] {
        SYS_MACH = 4'd0,
        SYS_MACL = 4'd1,
        SYS_GBR  = 4'd2,
        SYS_PR   = 4'd3,
        SYS_SR   = 4'd4,
        SYS_PC   = 4'd5,
        SYS_SSR  = 4'd6,
        SYS_VBR  = 4'd7,
        SYS_SPC  = 4'd8
    } sys_sel_e;

endpackage

// File: rtl/rf_bank_ctrl.sv
module rf_bank_ctrl
    import banked_rf_pkg::*;
(
    input  logic       priv_i,
    input  logic       bank_bit_i,
    input  logic       alt_rd_en_i,
    input  logic       alt_wr_en_i,
    input  logic       sys_rd_en_i,
    input  logic       sys_wr_en_i,
    input  logic [3:0] sys_sel_i,
    output logic       act_bank_o,
    output logic       alt_bank_o,
    output logic       alt_bad_o,
    output logic       sys_bad_o
);

    logic priv_only_sel;

    always_comb begin
        // the active copy only moves off bank 0 under privilege
        act_bank_o = priv_i & bank_bit_i;
        alt_bank_o = ~(priv_i & bank_bit_i);

        priv_only_sel = (sys_sel_i == SYS_SSR) ||
                        (sys_sel_i == SYS_VBR) ||
                        (sys_sel_i == SYS_SPC);

        alt_bad_o = ~priv_i & (alt_rd_en_i | alt_wr_en_i);
        sys_bad_o = ~priv_i & (sys_rd_en_i | sys_wr_en_i) & priv_only_sel;
    end

endmodule

// File: rtl/rf_gpr_array.sv
module rf_gpr_array #(
    parameter int DATA_W     = 32,
    parameter int NBANK_REGS = 8,
    parameter int NSHARED    = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        act_bank_i,
    input  logic                        alt_bank_i,
    input  logic [$clog2(NBANK_REGS+NSHARED)-1:0] rd_a_addr_i,
    input  logic [$clog2(NBANK_REGS+NSHARED)-1:0] rd_b_addr_i,
    input  logic                        wr_en_i,
    input  logic [$clog2(NBANK_REGS+NSHARED)-1:0] wr_addr_i,
    input  logic [DATA_W-1:0]           wr_data_i,
    input  logic [$clog2(NBANK_REGS)-1:0] alt_addr_i,
    input  logic                        alt_we_i,
    input  logic [DATA_W-1:0]           alt_wdata_i,
    output logic [DATA_W-1:0]           rd_a_data_o,
    output logic [DATA_W-1:0]           rd_b_data_o,
    output logic [DATA_W-1:0]           alt_rdata_o,
    output logic [DATA_W-1:0]           idx_data_o
);

    localparam int NREGS = NBANK_REGS + NSHARED;
    localparam int AW    = $clog2(NREGS);
    localparam int BW    = $clog2(NBANK_REGS);
    localparam int SW    = $clog2(NSHARED);

    typedef struct packed {
        logic [NBANK_REGS-1:0][DATA_W-1:0] bank0;
        logic [NBANK_REGS-1:0][DATA_W-1:0] bank1;
        logic [NSHARED-1:0][DATA_W-1:0]    common;
    } gpr_state_t;

    gpr_state_t st_d, st_q;

    function automatic logic [DATA_W-1:0] read_gpr(input gpr_state_t s,
                                                   input logic [AW-1:0] a,
                                                   input logic bsel);
        logic [AW-1:0] off;
        off = a - AW'(NBANK_REGS);
        if (a < AW'(NBANK_REGS)) begin
            read_gpr = bsel ? s.bank1[a[BW-1:0]] : s.bank0[a[BW-1:0]];
        end else begin
            read_gpr = s.common[off[SW-1:0]];
        end
    endfunction

    // read side: old contents until the clock edge
    always_comb begin
        rd_a_data_o = read_gpr(st_q, rd_a_addr_i, act_bank_i);
        rd_b_data_o = read_gpr(st_q, rd_b_addr_i, act_bank_i);
        idx_data_o  = read_gpr(st_q, '0, act_bank_i);
        alt_rdata_o = alt_bank_i ? st_q.bank1[alt_addr_i] : st_q.bank0[alt_addr_i];
    end

    // next-state computation
    always_comb begin
        logic [AW-1:0] woff;
        st_d = st_q;
        woff = wr_addr_i - AW'(NBANK_REGS);
        if (alt_we_i) begin
            if (alt_bank_i) st_d.bank1[alt_addr_i] = alt_wdata_i;
            else            st_d.bank0[alt_addr_i] = alt_wdata_i;
        end
        if (wr_en_i) begin
            if (wr_addr_i < AW'(NBANK_REGS)) begin
                if (act_bank_i) st_d.bank1[wr_addr_i[BW-1:0]] = wr_data_i;
                else            st_d.bank0[wr_addr_i[BW-1:0]] = wr_data_i;
            end else begin
                st_d.common[woff[SW-1:0]] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R1: reset leaves every general register cleared
    p_gpr_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (st_q == '0));

    // R7: with no write let through, contents hold
    p_gpr_quiet_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && !alt_we_i) |=> $stable(st_q));

endmodule

// File: rtl/rf_sys_regs.sv
module rf_sys_regs
    import banked_rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        sel_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              priv_o,
    output logic              bank_bit_o
);

    localparam logic [DATA_W-1:0] SR_RST =
        (DATA_W'(1) << SR_PRIV_BIT) | (DATA_W'(1) << SR_BANK_BIT);

    typedef struct packed {
        logic [DATA_W-1:0] mach;
        logic [DATA_W-1:0] macl;
        logic [DATA_W-1:0] gbr;
        logic [DATA_W-1:0] pr;
        logic [DATA_W-1:0] sr;
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] ssr;
        logic [DATA_W-1:0] vbr;
        logic [DATA_W-1:0] spc;
    } sys_state_t;

    sys_state_t st_d, st_q;

    always_comb begin
        case (sel_i)
            SYS_MACH: rdata_o = st_q.mach;
            SYS_MACL: rdata_o = st_q.macl;
            SYS_GBR:  rdata_o = st_q.gbr;
            SYS_PR:   rdata_o = st_q.pr;
            SYS_SR:   rdata_o = st_q.sr;
            SYS_PC:   rdata_o = st_q.pc;
            SYS_SSR:  rdata_o = st_q.ssr;
            SYS_VBR:  rdata_o = st_q.vbr;
            SYS_SPC:  rdata_o = st_q.spc;
            default:  rdata_o = '0;
        endcase
        priv_o     = st_q.sr[SR_PRIV_BIT];
        bank_bit_o = st_q.sr[SR_BANK_BIT];
    end

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            case (sel_i)
                SYS_MACH: st_d.mach = wdata_i;
                SYS_MACL: st_d.macl = wdata_i;
                SYS_GBR:  st_d.gbr  = wdata_i;
                SYS_PR:   st_d.pr   = wdata_i;
                SYS_SR:   st_d.sr   = wdata_i;
                SYS_PC:   st_d.pc   = wdata_i;
                SYS_SSR:  st_d.ssr  = wdata_i;
                SYS_VBR:  st_d.vbr  = wdata_i;
                SYS_SPC:  st_d.spc  = wdata_i;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '0;
            st_q.sr <= SR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: reset state of status word and program counter
    p_sys_reset_value_r1: assert property (@(posedge clk)
        rst |=> (st_q.sr == SR_RST && st_q.pc == '0));

    // R10: writes to unmapped codes change nothing
    p_sys_unmapped_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (we_i && sel_i > SYS_SPC) |=> $stable(st_q));

    // R6: no system state moves without a granted write
    p_sys_no_write_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!we_i) |=> $stable(st_q));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import banked_rf_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NBANK_REGS = 8,
    parameter int NSHARED    = 8,
    localparam int AW        = $clog2(NBANK_REGS + NSHARED),
    localparam int BW        = $clog2(NBANK_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [AW-1:0]     rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              alt_rd_en,
    input  logic              alt_wr_en,
    input  logic [BW-1:0]     alt_addr,
    input  logic [DATA_W-1:0] alt_wdata,
    output logic [DATA_W-1:0] alt_rdata,
    input  logic              sys_rd_en,
    input  logic              sys_wr_en,
    input  logic [3:0]        sys_sel,
    input  logic [DATA_W-1:0] sys_wdata,
    output logic [DATA_W-1:0] sys_rdata,
    output logic [DATA_W-1:0] idx_data,
    output logic              illegal
);

    logic              priv, bank_bit;
    logic              act_bank, alt_bank;
    logic              alt_bad, sys_bad;
    logic              alt_we, sys_we;
    logic [DATA_W-1:0] alt_raw, sys_raw;

    rf_bank_ctrl u_ctrl (
        .priv_i      (priv),
        .bank_bit_i  (bank_bit),
        .alt_rd_en_i (alt_rd_en),
        .alt_wr_en_i (alt_wr_en),
        .sys_rd_en_i (sys_rd_en),
        .sys_wr_en_i (sys_wr_en),
        .sys_sel_i   (sys_sel),
        .act_bank_o  (act_bank),
        .alt_bank_o  (alt_bank),
        .alt_bad_o   (alt_bad),
        .sys_bad_o   (sys_bad)
    );

    always_comb begin
        alt_we    = alt_wr_en & ~alt_bad;
        sys_we    = sys_wr_en & ~sys_bad;
        alt_rdata = (alt_rd_en && !alt_bad) ? alt_raw : '0;
        sys_rdata = (sys_rd_en && !sys_bad) ? sys_raw : '0;
        illegal   = alt_bad | sys_bad;
    end

    rf_gpr_array #(
        .DATA_W     (DATA_W),
        .NBANK_REGS (NBANK_REGS),
        .NSHARED    (NSHARED)
    ) u_gpr (
        .clk         (clk),
        .rst         (rst),
        .act_bank_i  (act_bank),
        .alt_bank_i  (alt_bank),
        .rd_a_addr_i (rd_a_addr),
        .rd_b_addr_i (rd_b_addr),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .alt_addr_i  (alt_addr),
        .alt_we_i    (alt_we),
        .alt_wdata_i (alt_wdata),
        .rd_a_data_o (rd_a_data),
        .rd_b_data_o (rd_b_data),
        .alt_rdata_o (alt_raw),
        .idx_data_o  (idx_data)
    );

    rf_sys_regs #(
        .DATA_W (DATA_W)
    ) u_sys (
        .clk        (clk),
        .rst        (rst),
        .sel_i      (sys_sel),
        .we_i       (sys_we),
        .wdata_i    (sys_wdata),
        .rdata_o    (sys_raw),
        .priv_o     (priv),
        .bank_bit_o (bank_bit)
    );

    // R2: user mode never selects bank 1
    p_user_bank0_r2: assert property (@(posedge clk) disable iff (rst)
        !priv |-> !act_bank);

    // R3: privileged mode follows the status bank bit
    p_priv_bank_follow_r3: assert property (@(posedge clk) disable iff (rst)
        priv |-> (act_bank == bank_bit));

    // R5: alternate port always faces the other copy under privilege
    p_alt_opposite_r5: assert property (@(posedge clk) disable iff (rst)
        priv |-> (alt_bank != act_bank));

    // R6: refusals happen only in user mode
    p_illegal_user_only_r6: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !priv);

    // R6: refused alternate reads leak nothing
    p_alt_refused_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (alt_rd_en && !priv) |-> (alt_rdata == '0 && illegal));

endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  rd_a_addr, rd_b_addr, wr_addr, sys_sel;
    logic [31:0] rd_a_data, rd_b_data, wr_data, alt_wdata, alt_rdata;
    logic [31:0] sys_wdata, sys_rdata, idx_data;
    logic        wr_en, alt_rd_en, alt_wr_en, sys_rd_en, sys_wr_en, illegal;
    logic [2:0]  alt_addr;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference model
    logic [31:0] m_b0 [8];
    logic [31:0] m_b1 [8];
    logic [31:0] m_hi [8];
    logic [31:0] m_sys[9];

    always #10 clk = ~clk;

    banked_regfile u_banked_regfile (
        .clk       (clk),
        .rst       (rst),
        .rd_a_addr (rd_a_addr),
        .rd_a_data (rd_a_data),
        .rd_b_addr (rd_b_addr),
        .rd_b_data (rd_b_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .alt_rd_en (alt_rd_en),
        .alt_wr_en (alt_wr_en),
        .alt_addr  (alt_addr),
        .alt_wdata (alt_wdata),
        .alt_rdata (alt_rdata),
        .sys_rd_en (sys_rd_en),
        .sys_wr_en (sys_wr_en),
        .sys_sel   (sys_sel),
        .sys_wdata (sys_wdata),
        .sys_rdata (sys_rdata),
        .idx_data  (idx_data),
        .illegal   (illegal)
    );

    function automatic bit m_priv();
        return m_sys[4][30];
    endfunction

    function automatic bit m_bank();
        return m_sys[4][30] & m_sys[4][29];
    endfunction

    function automatic logic [31:0] exp_gpr(input int a);
        if (a >= 8) return m_hi[a-8];
        return m_bank() ? m_b1[a] : m_b0[a];
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_total++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic clr();
        wr_en = 0; alt_rd_en = 0; alt_wr_en = 0; sys_rd_en = 0; sys_wr_en = 0;
    endtask

    task automatic gpr_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = 4'(a); wr_data = d;
        @(posedge clk); #1;
        clr();
        if (a >= 8) m_hi[a-8] = d;
        else if (m_bank()) m_b1[a] = d;
        else m_b0[a] = d;
    endtask

    task automatic alt_wr(input int a, input logic [31:0] d, input string tag);
        bit p;
        p = m_priv();
        @(negedge clk);
        alt_wr_en = 1; alt_addr = 3'(a); alt_wdata = d;
        #2 chk(tag, {31'd0, illegal}, {31'd0, ~p});
        @(posedge clk); #1;
        clr();
        if (p) begin
            if (m_bank()) m_b0[a] = d;
            else m_b1[a] = d;
        end
    endtask

    task automatic sys_wr(input int c, input logic [31:0] d, input string tag);
        bit bad;
        bad = !m_priv() && (c >= 6 && c <= 8);
        @(negedge clk);
        sys_wr_en = 1; sys_sel = 4'(c); sys_wdata = d;
        #2 chk(tag, {31'd0, illegal}, {31'd0, bad});
        @(posedge clk); #1;
        clr();
        if (!bad && c <= 8) m_sys[c] = d;
    endtask

    task automatic gpr_rd(input int a, input string tag);
        @(negedge clk);
        rd_a_addr = 4'(a); rd_b_addr = 4'(15 - a);
        #2;
        chk(tag, rd_a_data, exp_gpr(a));
        chk(tag, rd_b_data, exp_gpr(15 - a));
    endtask

    task automatic alt_rd(input int a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        alt_rd_en = 1; alt_addr = 3'(a);
        #2;
        if (!m_priv()) e = 32'd0;
        else e = m_bank() ? m_b0[a] : m_b1[a];
        chk(tag, alt_rdata, e);
        chk(tag, {31'd0, illegal}, {31'd0, ~m_priv()});
        clr();
    endtask

    task automatic sys_rd(input int c, input string tag);
        logic [31:0] e;
        bit bad;
        bad = !m_priv() && (c >= 6 && c <= 8);
        @(negedge clk);
        sys_rd_en = 1; sys_sel = 4'(c);
        #2;
        e = (bad || c > 8) ? 32'd0 : m_sys[c];
        chk(tag, sys_rdata, e);
        chk(tag, {31'd0, illegal}, {31'd0, bad});
        clr();
    endtask

    task automatic sweep();
        string t;
        t = m_priv() ? "R3" : "R2";
        for (int a = 0; a < 8; a++) gpr_rd(a, t);
        for (int a = 8; a < 16; a++) gpr_rd(a, "R4");
        #1 chk("R8 index", idx_data, exp_gpr(0));
        for (int a = 0; a < 8; a++) alt_rd(a, m_priv() ? "R5" : "R6");
    endtask

    initial begin
        logic [31:0] srs [4];
        srs[0] = 32'h6000_0000; srs[1] = 32'h4000_00F0;
        srs[2] = 32'h0000_0000; srs[3] = 32'h2000_0000;
        for (int i = 0; i < 8; i++) begin m_b0[i] = 0; m_b1[i] = 0; m_hi[i] = 0; end
        for (int i = 0; i < 9; i++) m_sys[i] = 0;
        m_sys[4] = 32'h6000_0000;
        rst = 1; clr();
        rd_a_addr = 0; rd_b_addr = 0; wr_addr = 0; wr_data = 0;
        alt_addr = 0; alt_wdata = 0; sys_sel = 0; sys_wdata = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset state
        for (int a = 0; a < 16; a++) gpr_rd(a, "R1 gpr");
        for (int c = 0; c < 9; c++) sys_rd(c, "R1 sys");
        alt_rd(3, "R1 alt");

        // R9: every system register written and read back under privilege
        for (int c = 0; c < 9; c++)
            if (c != 4) sys_wr(c, 32'hC000_0000 | c, "R9 wr");
        for (int c = 0; c < 9; c++) sys_rd(c, "R9 rd");

        // fill bank 1 and shared via the normal port, bank 0 via the alternate port
        for (int a = 0; a < 16; a++) gpr_wr(a, 32'hA100_0000 | a);
        for (int a = 0; a < 8; a++) alt_wr(a, 32'hB000_0000 | a, "R5 wr");

        for (int s = 0; s < 4; s++) begin
            sys_wr(4, srs[s], "R9 sr");
            sweep();
            sys_rd(4, "R9 sr rd");
        end

        // user mode writes go to bank 0, shared written from user mode
        gpr_wr(2, 32'hD000_0002);
        gpr_wr(12, 32'hD000_000C);
        // R6: refused operations in user mode
        alt_wr(5, 32'hDEAD_0005, "R6 alt wr");
        sys_wr(6, 32'hDEAD_0006, "R6 ssr wr");
        sys_wr(8, 32'hDEAD_0008, "R6 spc wr");
        sys_rd(7, "R6 vbr rd");
        sys_rd(0, "R9 user mach");
        sys_wr(2, 32'h1234_5678, "R9 user gbr");
        sys_rd(2, "R9 user gbr rd");

        // back to privileged bank 1: nothing refused left a trace
        sys_wr(4, 32'h6000_0000, "R9 sr");
        sweep();
        for (int c = 0; c < 9; c++) sys_rd(c, "R6 after");
        // privileged bank 0 write via normal port lands in bank 0
        sys_wr(4, 32'h4000_0000, "R9 sr");
        gpr_wr(1, 32'hE000_0001);
        sys_wr(4, 32'h6000_0000, "R9 sr");
        alt_rd(1, "R5 bank0 via alt");
        alt_wr(6, 32'hF000_0006, "R5 alt wr b0");
        sweep();

        // R7: read during write sees old value, new value next cycle
        @(negedge clk);
        wr_en = 1; wr_addr = 4'd3; wr_data = 32'h7777_0003; rd_a_addr = 4'd3;
        #2 chk("R7 same cycle", rd_a_data, exp_gpr(3));
        @(posedge clk); #1;
        clr();
        m_b1[3] = 32'h7777_0003;
        #2 chk("R7 next cycle", rd_a_data, 32'h7777_0003);

        // R9: status write flips banking only from the next cycle
        @(negedge clk);
        sys_wr_en = 1; sys_sel = 4'd4; sys_wdata = 32'h4000_0000; rd_a_addr = 4'd0;
        #2 chk("R9 sr old bank", rd_a_data, m_b1[0]);
        chk("R8 old bank", idx_data, m_b1[0]);
        @(posedge clk); #1;
        clr();
        m_sys[4] = 32'h4000_0000;
        #2 chk("R9 sr new bank", rd_a_data, m_b0[0]);
        chk("R8 new bank", idx_data, m_b0[0]);

        // R10: unmapped codes and disabled reads
        sys_wr(12, 32'h5555_AAAA, "R10 unmapped wr");
        sys_rd(12, "R10 unmapped rd");
        sys_rd(15, "R10 unmapped rd");
        @(negedge clk);
        sys_sel = 4'd0;
        #2 chk("R10 rd disabled", sys_rdata, 32'd0);
        for (int c = 0; c < 9; c++) sys_rd(c, "R10 after");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule